// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Read Target

This block is the target side of a firmware-memory read transaction carried on a 4-bit multiplexed bus. The host marks the start of a transaction with an active-low frame strobe and a start code. The transaction then carries the following, one nibble per clock:

- a device-select nibble;
- a 28-bit address, sent as seven nibbles;
- a size nibble;
- a turnaround nibble.

When the select nibble matches the strap inputs and the size is one byte, the target takes the bus and answers with two short-wait sync nibbles and one ready nibble. It then sends the addressed byte low nibble first, drives one turnaround nibble and releases the bus. The transaction is nineteen clocks long in total.

The byte comes from a storage array through a simple read port. The target places the low address bits on the port and pulses a read strobe during the first wait-sync clock. The array returns the byte on the next clock.

The target never drives the bus in the following cases:

- the select nibble does not match;
- the host opens a transaction with a code other than the read start code.

An illegal size, or a frame strobe that falls again part way through a transaction, ends the transaction. The target then releases the bus and flags the event for one clock.

Top module: `nbr_target`

## Requirements
- R1: While `rst` is high and in the first clock after it, `bus_oe`, `arr_rd` and `abort_o` are all 0. A reset in the middle of a transaction releases the bus in the next clock.
- R2: A transaction starts only on a clock edge where `frame_n` is 0 and `bus_i` is 4'b1101. A frame strobe carrying any other nibble (for example 4'b1100) is ignored, so the target never drives the bus for that transaction.
- R3: The nibble in the clock after the start code is compared with `strap`. On a mismatch the target never drives the bus, issues no array read and raises no abort for the rest of the transaction.
- R4: Address nibbles in clocks 3 to 9 arrive most significant first. `arr_addr` equals bits 18:0 of the assembled 28-bit address. `arr_rd` is high for exactly one clock, clock 13, in each completed transaction.
- R5: A size nibble (clock 10) other than 4'b0000 makes `abort_o` high in clock 11. The target then never drives the bus and issues no array read.
- R6: In clocks 1 to 11 the target leaves `bus_oe` at 0. In clock 12 it drives 4'b1111.
- R7: In clocks 13 and 14 the target drives 4'b0101, and in clock 15 it drives 4'b0000.
- R8: In clock 16 the target drives bits 3:0 of the byte read from the array, and in clock 17 it drives bits 7:4.
- R9: In clock 18 the target drives 4'b1111. In clock 19 `bus_oe` is 0.
- R10: If `frame_n` is sampled 0 in any clock from 2 to 18 of an accepted transaction, `abort_o` is high for one clock and `bus_oe` is 0 from the next clock on. A later transaction is then served normally.
- R11: A start code presented in clock 19 begins a new transaction at once, and that transaction is served completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low transaction frame strobe |
| bus_i | input | 4 | Nibble sampled from the bus |
| bus_o | output | 4 | Nibble driven onto the bus |
| bus_oe | output | 1 | Target owns the bus when high |
| strap | input | 4 | Device identity compared with the select nibble |
| arr_addr | output | 19 | Array byte address |
| arr_rd | output | 1 | One-clock read strobe; data expected on the next clock |
| arr_rdata | input | 8 | Byte returned by the array |
| abort_o | output | 1 | One-clock pulse when a transaction is abandoned |

## Verification
The bench checks every clock of each transaction against a position-by-position schedule of bus ownership and nibble values. A design that shifted the address the wrong way or swapped the data nibbles would put the wrong address on the array port or the wrong nibble in clocks 16 and 17. A design with an off-by-one wait count would move the ready code or the release clock.

The bench also covers the following cases:

- a select mismatch, where a careless design would still drive the bus;
- a bad size code, where it would return data instead of aborting;
- a start code other than the read code;
- a frame strobe falling during the wait-sync clocks;
- a reset in the middle of a transaction;
- a start code in clock 19, which a design that lingered one clock too long in its final state would miss.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    localparam int NIB_W      = 4;
    localparam int ADDR_NIBS  = 7;
    localparam int ARR_AW     = 19;
    localparam int WAIT_CYC   = 2;
    localparam int BYTE_W     = 8;

    typedef logic [NIB_W-1:0] nib_t;

    localparam nib_t CODE_START = 4'b1101;
    localparam nib_t CODE_TURN  = 4'b1111;
    localparam nib_t CODE_WAIT  = 4'b0101;
    localparam nib_t CODE_READY = 4'b0000;
    localparam nib_t CODE_SIZE1 = 4'b0000;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SEL,
        PH_ADDR,
        PH_SIZE,
        PH_TURN_HOST,
        PH_TURN_TGT,
        PH_WAIT,
        PH_READY,
        PH_DATA_LO,
        PH_DATA_HI,
        PH_TURN_END
    } phase_e;

    typedef struct packed {
        logic oe;
        nib_t val;
    } drive_t;

    function automatic logic is_read_start(input logic frame_n, input nib_t nib);
        return (!frame_n) && (nib == CODE_START);
    endfunction

    function automatic nib_t byte_nibble(input logic [BYTE_W-1:0] b, input logic hi);
        return hi ? b[BYTE_W-1 -: NIB_W] : b[NIB_W-1:0];
    endfunction

endpackage

// File: rtl/nbr_seq.sv
module nbr_seq
    import nbr_pkg::*;
#(
    parameter int ADDR_N = ADDR_NIBS,
    parameter int WAIT_N = WAIT_CYC
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_n,
    input  nib_t   bus_i,
    input  nib_t   strap,
    output phase_e phase,
    output logic   shift_en,
    output logic   rd_issue,
    output logic   abort_now
);

    localparam int MAXC = (ADDR_N > WAIT_N) ? ADDR_N : WAIT_N;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_N - 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_N - 1);

    phase_e        ph_q, ph_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        ph_d      = ph_q;
        cnt_d     = cnt_q;
        abort_now = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (is_read_start(frame_n, bus_i)) ph_d = PH_SEL;
            end
            PH_SEL: begin
                cnt_d = '0;
                ph_d  = (bus_i == strap) ? PH_ADDR : PH_IDLE;
            end
            PH_ADDR: begin
                if (cnt_q == ADDR_LAST) ph_d = PH_SIZE;
                else                    cnt_d = cnt_q + 1'b1;
            end
            PH_SIZE: begin
                if (bus_i == CODE_SIZE1) begin
                    ph_d = PH_TURN_HOST;
                end else begin
                    ph_d      = PH_IDLE;
                    abort_now = 1'b1;
                end
            end
            PH_TURN_HOST: ph_d = PH_TURN_TGT;
            PH_TURN_TGT: begin
                ph_d  = PH_WAIT;
                cnt_d = '0;
            end
            PH_WAIT: begin
                if (cnt_q == WAIT_LAST) ph_d = PH_READY;
                else                    cnt_d = cnt_q + 1'b1;
            end
            PH_READY:    ph_d = PH_DATA_LO;
            PH_DATA_LO:  ph_d = PH_DATA_HI;
            PH_DATA_HI:  ph_d = PH_TURN_END;
            PH_TURN_END: ph_d = PH_IDLE;
            default:     ph_d = PH_IDLE;
        endcase
        if (ph_q != PH_IDLE && !frame_n) begin
            ph_d      = PH_IDLE;
            abort_now = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    assign phase    = ph_q;
    assign shift_en = (ph_q == PH_ADDR);
    assign rd_issue = (ph_q == PH_WAIT) && (cnt_q == '0);

endmodule

// File: rtl/nbr_addr_asm.sv
module nbr_addr_asm
    import nbr_pkg::*;
#(
    parameter int OUT_W = ARR_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  nib_t             nib,
    output logic [OUT_W-1:0] addr
);

    logic [OUT_W-1:0] addr_q;

    generate
        if (OUT_W > NIB_W) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst)           addr_q <= '0;
                else if (shift_en) addr_q <= {addr_q[OUT_W-NIB_W-1:0], nib};
            end
        end else begin : g_narrow
            always_ff @(posedge clk) begin
                if (rst)           addr_q <= '0;
                else if (shift_en) addr_q <= nib[OUT_W-1:0];
            end
        end
    endgenerate

    assign addr = addr_q;

endmodule

// File: rtl/nbr_bus_drv.sv
module nbr_bus_drv
    import nbr_pkg::*;
(
    input  phase_e            phase,
    input  logic [BYTE_W-1:0] data_q,
    output nib_t              bus_o,
    output logic              bus_oe
);

    drive_t drv;

    always_comb begin
        drv = '{oe: 1'b0, val: CODE_TURN};
        unique case (phase)
            PH_TURN_TGT: drv = '{oe: 1'b1, val: CODE_TURN};
            PH_WAIT:     drv = '{oe: 1'b1, val: CODE_WAIT};
            PH_READY:    drv = '{oe: 1'b1, val: CODE_READY};
            PH_DATA_LO:  drv = '{oe: 1'b1, val: byte_nibble(data_q, 1'b0)};
            PH_DATA_HI:  drv = '{oe: 1'b1, val: byte_nibble(data_q, 1'b1)};
            PH_TURN_END: drv = '{oe: 1'b1, val: CODE_TURN};
            default:     drv = '{oe: 1'b0, val: CODE_TURN};
        endcase
    end

    assign bus_o  = drv.val;
    assign bus_oe = drv.oe;

endmodule

// File: rtl/nbr_target.sv
module nbr_target
    import nbr_pkg::*;
#(
    parameter int ADDR_N = ADDR_NIBS,
    parameter int AW     = ARR_AW,
    parameter int WAIT_N = WAIT_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        bus_i,
    output logic [3:0]        bus_o,
    output logic              bus_oe,
    input  logic [3:0]        strap,
    output logic [AW-1:0]     arr_addr,
    output logic              arr_rd,
    input  logic [BYTE_W-1:0] arr_rdata,
    output logic              abort_o
);

    phase_e            phase;
    logic              shift_en, rd_issue, abort_now;
    logic              rd_q, abort_q;
    logic [BYTE_W-1:0] data_q;

    nbr_seq #(.ADDR_N(ADDR_N), .WAIT_N(WAIT_N)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .frame_n   (frame_n),
        .bus_i     (bus_i),
        .strap     (strap),
        .phase     (phase),
        .shift_en  (shift_en),
        .rd_issue  (rd_issue),
        .abort_now (abort_now)
    );

    nbr_addr_asm #(.OUT_W(AW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .nib      (bus_i),
        .addr     (arr_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= 1'b0;
            abort_q <= 1'b0;
            data_q  <= '0;
        end else begin
            rd_q    <= rd_issue;
            abort_q <= abort_now;
            if (rd_q) data_q <= arr_rdata;
        end
    end

    nbr_bus_drv u_drv (
        .phase  (phase),
        .data_q (data_q),
        .bus_o  (bus_o),
        .bus_oe (bus_oe)
    );

    assign arr_rd  = rd_issue;
    assign abort_o = abort_q;

endmodule

// File: rtl/nbr_target_chk.sv
module nbr_target_chk
    import nbr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] bus_o,
    input logic       bus_oe,
    input logic       arr_rd,
    input logic       abort_o
);

    // R6: the first clock of bus ownership carries the turnaround code
    a_r6_take_with_turn: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> (bus_o == CODE_TURN));

    // R7: the ready code is followed by a driven data nibble unless the transaction is abandoned
    a_r7_ready_then_data: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && bus_o == CODE_READY) |=> (bus_oe || abort_o));

    // R4: the array strobe lasts a single clock
    a_r4_rd_single: assert property (@(posedge clk) disable iff (rst)
        arr_rd |=> !arr_rd);

    // R4: the array strobe falls in a wait-sync clock
    a_r4_rd_in_wait: assert property (@(posedge clk) disable iff (rst)
        arr_rd |-> (bus_oe && bus_o == CODE_WAIT));

    // R9: the bus is released only after a driven turnaround, an abort or a reset
    a_r9_release_after_turn: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_oe) |-> (($past(bus_o) == CODE_TURN) || abort_o || $past(rst)));

    // R5, R10: an abort never coincides with bus ownership
    a_r10_abort_released: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> !bus_oe);

endmodule

bind nbr_target nbr_target_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_o   (bus_o),
    .bus_oe  (bus_oe),
    .arr_rd  (arr_rd),
    .abort_o (abort_o)
);

// File: tb/sim_nbr_target.sv
module sim_nbr_target;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;
    localparam logic [3:0] START = 4'b1101;

    // {strap, select, size, address}
    localparam logic [39:0] VEC [NVEC] = '{
        {4'h3, 4'h3, 4'h0, 28'h0012345},
        {4'h3, 4'h3, 4'h0, 28'hFFFFFFF},
        {4'hA, 4'hA, 4'h0, 28'h0ABCDE5},
        {4'h3, 4'h5, 4'h0, 28'h0012345},
        {4'h3, 4'h3, 4'h1, 28'h0012345},
        {4'h0, 4'h0, 4'h0, 28'h0000000},
        {4'hF, 4'hF, 4'h0, 28'h1234567},
        {4'h3, 4'h3, 4'hF, 28'h7654321}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic [3:0]  bus_i = 4'hF;
    logic [3:0]  strap = 4'h3;
    logic [3:0]  bus_o;
    logic        bus_oe;
    logic [18:0] arr_addr;
    logic        arr_rd;
    logic [7:0]  arr_rdata = 8'h00;
    logic        abort_o;

    int n_chk = 0;
    int n_fail = 0;

    logic        ob_oe   [1:20];
    logic [3:0]  ob_o    [1:20];
    logic        ob_rd   [1:20];
    logic        ob_ab   [1:20];
    logic [18:0] ob_addr [1:20];

    always #(CLK_PERIOD/2) clk = ~clk;

    nbr_target u0 (
        .clk       (clk),
        .rst       (rst),
        .frame_n   (frame_n),
        .bus_i     (bus_i),
        .bus_o     (bus_o),
        .bus_oe    (bus_oe),
        .strap     (strap),
        .arr_addr  (arr_addr),
        .arr_rd    (arr_rd),
        .arr_rdata (arr_rdata),
        .abort_o   (abort_o)
    );

    function automatic logic [7:0] memf(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {a[18:16], 5'b10110};
    endfunction

    always @(posedge clk) if (arr_rd) arr_rdata <= memf(arr_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int k, input logic f, input logic [3:0] n);
        ob_oe[k]   = bus_oe;
        ob_o[k]    = bus_o;
        ob_rd[k]   = arr_rd;
        ob_ab[k]   = abort_o;
        ob_addr[k] = arr_addr;
        frame_n = f;
        bus_i   = n;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_read(input logic [3:0] snib, input logic [3:0] sel,
                            input logic [3:0] size, input logic [27:0] addr,
                            input bit skip_start, input bit chain,
                            input int abort_at, input int rst_at, input int last);
        for (int k = 1; k <= 20; k++) begin
            ob_oe[k] = 1'b0; ob_o[k] = 4'hF; ob_rd[k] = 1'b0;
            ob_ab[k] = 1'b0; ob_addr[k] = '0;
        end
        for (int k = (skip_start ? 2 : 1); k <= last; k++) begin
            logic       f;
            logic [3:0] n;
            f = 1'b1;
            n = 4'hF;
            if (k == 1)       begin f = 1'b0; n = snib; end
            else if (k == 2)  n = sel;
            else if (k <= 9)  n = addr[27-4*(k-3) -: 4];
            else if (k == 10) n = size;
            if (k == 19 && chain) begin f = 1'b0; n = START; end
            if (k == abort_at)    begin f = 1'b0; n = 4'h0; end
            rst = (k == rst_at);
            step(k, f, n);
        end
        rst = 1'b0;
    endtask

    function automatic int oe_cnt(input int a, input int b);
        int c = 0;
        for (int k = a; k <= b; k++) if (ob_oe[k]) c++;
        return c;
    endfunction

    function automatic int rd_cnt(input int a, input int b);
        int c = 0;
        for (int k = a; k <= b; k++) if (ob_rd[k]) c++;
        return c;
    endfunction

    function automatic int ab_cnt(input int a, input int b);
        int c = 0;
        for (int k = a; k <= b; k++) if (ob_ab[k]) c++;
        return c;
    endfunction

    task automatic check_good(input logic [27:0] addr, input int first);
        logic [7:0] exp_b;
        exp_b = memf(addr[18:0]);
        chk(oe_cnt(first, 11) == 0, "R6", "driven clocks before 12", oe_cnt(first, 11), 0);
        chk({ob_oe[12], ob_o[12]} == 5'h1F, "R6", "clock 12", {ob_oe[12], ob_o[12]}, 5'h1F);
        chk({ob_oe[13], ob_o[13]} == 5'h15, "R7", "clock 13", {ob_oe[13], ob_o[13]}, 5'h15);
        chk({ob_oe[14], ob_o[14]} == 5'h15, "R7", "clock 14", {ob_oe[14], ob_o[14]}, 5'h15);
        chk({ob_oe[15], ob_o[15]} == 5'h10, "R7", "clock 15", {ob_oe[15], ob_o[15]}, 5'h10);
        chk(ob_rd[13] && rd_cnt(first, 19) == 1, "R4", "read strobe count", rd_cnt(first, 19), 1);
        chk(ob_addr[13] == addr[18:0], "R4", "array address", ob_addr[13], addr[18:0]);
        chk({ob_oe[16], ob_o[16]} == {1'b1, exp_b[3:0]}, "R8", "low nibble",
            {ob_oe[16], ob_o[16]}, {1'b1, exp_b[3:0]});
        chk({ob_oe[17], ob_o[17]} == {1'b1, exp_b[7:4]}, "R8", "high nibble",
            {ob_oe[17], ob_o[17]}, {1'b1, exp_b[7:4]});
        chk({ob_oe[18], ob_o[18]} == 5'h1F, "R9", "clock 18", {ob_oe[18], ob_o[18]}, 5'h1F);
        chk(ob_oe[19] == 1'b0, "R9", "clock 19 released", ob_oe[19], 0);
    endtask

    task automatic check_silent(input string req);
        chk(oe_cnt(1, 20) == 0, req, "driven clocks", oe_cnt(1, 20), 0);
        chk(rd_cnt(1, 20) == 0, req, "array reads", rd_cnt(1, 20), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: outputs quiet while reset is held
        chk({bus_oe, arr_rd, abort_o} == 3'b000, "R1", "during reset", {bus_oe, arr_rd, abort_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({bus_oe, arr_rd, abort_o} == 3'b000, "R1", "after reset", {bus_oe, arr_rd, abort_o}, 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [39:0] v;
            v = VEC[i];
            strap = v[39:36];
            run_read(START, v[35:32], v[31:28], v[27:0], 1'b0, 1'b0, 0, 0, 20);
            if (v[39:36] != v[35:32]) begin
                check_silent("R3");
                chk(ab_cnt(1, 20) == 0, "R3", "abort on mismatch", ab_cnt(1, 20), 0);
            end else if (v[31:28] != 4'h0) begin
                check_silent("R5");
                chk(ob_ab[11] == 1'b1, "R5", "abort in clock 11", ob_ab[11], 1);
            end else begin
                check_good(v[27:0], 1);
            end
        end

        // R2: frame strobe with a non-read code
        strap = 4'h3;
        run_read(4'b1100, 4'h3, 4'h0, 28'h0012345, 1'b0, 1'b0, 0, 0, 20);
        check_silent("R2");

        // R10: frame strobe falls during wait-sync
        run_read(START, 4'h3, 4'h0, 28'h0040404, 1'b0, 1'b0, 14, 0, 20);
        chk(ob_ab[15] == 1'b1, "R10", "abort pulse", ob_ab[15], 1);
        chk(ab_cnt(16, 20) == 0, "R10", "abort width", ab_cnt(16, 20), 0);
        chk(oe_cnt(15, 20) == 0, "R10", "released after abort", oe_cnt(15, 20), 0);
        run_read(START, 4'h3, 4'h0, 28'h0055AA1, 1'b0, 1'b0, 0, 0, 20);
        check_good(28'h0055AA1, 1); // R10: next transaction served

        // R1: reset in mid-transaction
        run_read(START, 4'h3, 4'h0, 28'h0012345, 1'b0, 1'b0, 0, 14, 20);
        chk(oe_cnt(15, 20) == 0, "R1", "released after mid reset", oe_cnt(15, 20), 0);
        chk(ab_cnt(15, 20) == 0, "R1", "no abort from reset", ab_cnt(15, 20), 0);

        // R11: back-to-back transactions
        run_read(START, 4'h3, 4'h0, 28'h0031337, 1'b0, 1'b1, 0, 0, 19);
        check_good(28'h0031337, 1);
        run_read(START, 4'h3, 4'h0, 28'h007E0F1, 1'b1, 1'b0, 0, 0, 20);
        chk({ob_oe[16], ob_o[16]} == {1'b1, memf(19'h7E0F1) >> 0 & 8'h0F} || 1'b0 ? 1'b1 :
            ({ob_oe[16], ob_o[16]} == {1'b1, memf(19'h7E0F1)[3:0]}),
            "R11", "chained low nibble", {ob_oe[16], ob_o[16]}, {1'b1, memf(19'h7E0F1)[3:0]});
        check_good(28'h007E0F1, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule